// File: doc/BRIEF.md
# Vectored Interrupt Request Arbiter

This block sits next to a small 8-bit CPU core and merges its interrupt sources into one pending line and one vector fetch address. There are four sources. The first is a software-interrupt strobe raised when the core fetches the trap instruction. The second is a conditioned external request. The third is a timer request, formed from three flag/enable pairs. The fourth is a serial-port request, formed from five flag/enable pairs. The core's global mask input blocks the three hardware sources. It does not block the software interrupt.

At each instruction boundary the core pulses `boundary`. If anything is pending and no vector fetch is in progress, the block grants one source. It then pulses a one-hot acknowledge and latches the high-byte and low-byte vector addresses. Those addresses stay frozen until the core pulses `vec_done`.

When the software-interrupt strobe arrives, the block snapshots the hardware requests that are unmasked and pending at that moment. Those hardware requests are served before the software interrupt. Hardware requests that become pending later wait until after it.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `irq_pend` is 0, `ack` is 0, and both vector outputs are 0x0000.
- R2: A software-interrupt strobe is granted even when `mask` is 1. It yields `ack` = 4'b0001, `vec_hi_addr` = 0x1FFC and `vec_lo_addr` = 0x1FFD.
- R3: While `mask` is 1, the external, timer and serial requests raise neither `irq_pend` nor any acknowledge.
- R4: Among unmasked hardware requests, external wins over timer and timer wins over serial. The acknowledge bits are ext = bit 1, timer = bit 2, serial = bit 3. The vectors are 0x1FFA/0x1FFB for external, 0x1FF8/0x1FF9 for timer and 0x1FF6/0x1FF7 for serial.
- R5: The timer request is present only when at least one of the three bits `tmr_flag[i] & tmr_en[i]` is set. A flag whose enable is clear has no effect.
- R6: The serial request is present only when at least one of the five bits `ser_flag[i] & ser_en[i]` is set. A flag whose enable is clear has no effect.
- R7: A hardware request that was unmasked and pending when the software strobe arrived is granted before the software interrupt.
- R8: A hardware request that becomes pending after the software strobe is granted after the software interrupt.
- R9: `ack` is at most one-hot and lasts one cycle. It appears only in the cycle after a cycle in which `boundary` was 1.
- R10: After a grant, the vector outputs hold and no further grant occurs until `vec_done` is pulsed. During that time `irq_pend` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask | input | 1 | Global interrupt mask from the core; 1 blocks hardware sources |
| swi_req | input | 1 | One-cycle strobe: software-interrupt instruction fetched |
| ext_req | input | 1 | Conditioned external request level |
| tmr_flag | input | 3 | Timer event flags |
| tmr_en | input | 3 | Timer event enables |
| ser_flag | input | 5 | Serial-port event flags |
| ser_en | input | 5 | Serial-port event enables |
| boundary | input | 1 | Instruction-boundary strobe from the core |
| vec_done | input | 1 | Core has finished fetching the vector |
| irq_pend | output | 1 | A grantable request exists and no fetch is in progress |
| ack | output | 4 | One-hot grant pulse {serial, timer, ext, software} |
| vec_hi_addr | output | 16 | Address of the vector high byte |
| vec_lo_addr | output | 16 | Address of the vector low byte |

## Verification
The assertions assume that the core never raises `swi_req` in the same cycle as `boundary`. They also assume that `vec_done` arrives only while a fetch is in progress. The bench keeps to both rules: it drives each strobe in its own cycle, and it pulses `vec_done` only after it has seen an acknowledge. The assertions also assume that a peripheral drops its flag once acknowledged. After every grant, the bench clears the hardware inputs before the next boundary. It changes `mask` only between grants.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int          TMR_SRC = 3,
  parameter int          SER_SRC = 5,
  parameter logic [15:0] VEC_TOP = 16'h1FFC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask,
  input  logic               swi_req,
  input  logic               ext_req,
  input  logic [TMR_SRC-1:0] tmr_flag,
  input  logic [TMR_SRC-1:0] tmr_en,
  input  logic [SER_SRC-1:0] ser_flag,
  input  logic [SER_SRC-1:0] ser_en,
  input  logic               boundary,
  input  logic               vec_done,
  output logic               irq_pend,
  output logic [3:0]         ack,
  output logic [15:0]        vec_hi_addr,
  output logic [15:0]        vec_lo_addr
);

  logic       tmr_req, ser_req, swi_pend, busy, grant;
  logic [2:0] hw, snap, elig;
  logic [3:0] pick;
  logic [15:0] vec_sel;

  assign tmr_req = |(tmr_flag & tmr_en);
  assign ser_req = |(ser_flag & ser_en);
  assign hw      = {ser_req, tmr_req, ext_req} & {3{~mask}};
  assign elig    = swi_pend ? (snap & hw) : hw;

  always_comb begin
    pick    = 4'b0000;
    vec_sel = VEC_TOP;
    if (elig[0]) begin
      pick = 4'b0010; vec_sel = VEC_TOP - 16'd2;
    end else if (elig[1]) begin
      pick = 4'b0100; vec_sel = VEC_TOP - 16'd4;
    end else if (elig[2]) begin
      pick = 4'b1000; vec_sel = VEC_TOP - 16'd6;
    end else if (swi_pend || hw != 3'b000) begin
      pick = 4'b0001;
    end
  end

  assign irq_pend = (|pick) & ~busy;
  assign grant    = boundary & irq_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack         <= '0;
      busy        <= 1'b0;
      swi_pend    <= 1'b0;
      snap        <= '0;
      vec_hi_addr <= '0;
      vec_lo_addr <= '0;
    end else begin
      ack <= grant ? pick : 4'b0000;
      if (grant) begin
        busy        <= 1'b1;
        vec_hi_addr <= vec_sel;
        vec_lo_addr <= vec_sel + 16'd1;
      end else if (vec_done) begin
        busy <= 1'b0;
      end
      if (swi_req) begin
        swi_pend <= 1'b1;
        snap     <= hw;
      end else if (grant) begin
        if (pick[0]) swi_pend <= 1'b0;
        snap <= snap & ~pick[3:1];
      end
    end
  end

  // R9
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));
  // R9
  ack_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != 4'b0000) |-> $past(boundary));
  // R3
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[3:1] != 3'b000) |-> !$past(mask));
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !vec_done) |=> ($stable(vec_hi_addr) && $stable(vec_lo_addr) && ack == 4'b0000));
  // R2
  swi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack[0] |-> (vec_hi_addr == VEC_TOP && vec_lo_addr == VEC_TOP + 16'd1));
  // R4
  ext_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack[2] || ack[3]) && !$past(swi_pend)) |-> !$past(ext_req && !mask));

endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  logic clk = 0, rst_n = 0;
  logic mask = 1, swi_req = 0, ext_req = 0, boundary = 0, vec_done = 0;
  logic [2:0] tmr_flag = 0, tmr_en = 0;
  logic [4:0] ser_flag = 0, ser_en = 0;
  logic irq_pend;
  logic [3:0] ack;
  logic [15:0] vec_hi_addr, vec_lo_addr;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  irq_arbiter u_dut (.clk(clk), .rst_n(rst_n), .mask(mask), .swi_req(swi_req),
    .ext_req(ext_req), .tmr_flag(tmr_flag), .tmr_en(tmr_en), .ser_flag(ser_flag),
    .ser_en(ser_en), .boundary(boundary), .vec_done(vec_done), .irq_pend(irq_pend),
    .ack(ack), .vec_hi_addr(vec_hi_addr), .vec_lo_addr(vec_lo_addr));

  // {swi, mask, ext, tmr_flag, tmr_en, ser_flag, ser_en, exp_ack}
  localparam int NV = 12;
  localparam logic [22:0] TBL [NV] = '{
    {1'b0,1'b1,1'b1,3'b111,3'b111,5'b11111,5'b11111,4'b0000}, // R3
    {1'b0,1'b0,1'b1,3'b000,3'b000,5'b00000,5'b00000,4'b0010}, // R4 ext
    {1'b0,1'b0,1'b0,3'b001,3'b001,5'b00000,5'b00000,4'b0100}, // R5
    {1'b0,1'b0,1'b0,3'b100,3'b011,5'b00000,5'b00000,4'b0000}, // R5 disabled
    {1'b0,1'b0,1'b0,3'b010,3'b010,5'b00000,5'b00000,4'b0100}, // R5
    {1'b0,1'b0,1'b0,3'b000,3'b000,5'b10000,5'b10000,4'b1000}, // R6
    {1'b0,1'b0,1'b0,3'b000,3'b000,5'b01111,5'b10000,4'b0000}, // R6 disabled
    {1'b0,1'b0,1'b0,3'b000,3'b000,5'b00100,5'b00110,4'b1000}, // R6
    {1'b0,1'b0,1'b1,3'b100,3'b100,5'b00001,5'b00001,4'b0010}, // R4
    {1'b0,1'b0,1'b0,3'b100,3'b100,5'b00001,5'b00001,4'b0100}, // R4
    {1'b1,1'b1,1'b1,3'b000,3'b000,5'b00000,5'b00000,4'b0001}, // R2
    {1'b1,1'b0,1'b1,3'b000,3'b000,5'b00000,5'b00000,4'b0010}  // R7
  };

  function automatic logic [15:0] vec_of(input logic [3:0] a);
    case (a)
      4'b0001: return 16'h1FFC;
      4'b0010: return 16'h1FFA;
      4'b0100: return 16'h1FF8;
      4'b1000: return 16'h1FF6;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_swi();
    @(negedge clk) swi_req = 1;
    @(negedge clk) swi_req = 0;
  endtask

  task automatic at_boundary(input logic [3:0] exp, input string req);
    @(negedge clk) boundary = 1;
    @(negedge clk) boundary = 0;
    chk(ack == exp, req, ack, exp);
    if (exp != 0) chk(vec_hi_addr == vec_of(exp) && vec_lo_addr == vec_of(exp) + 16'd1,
                      req, vec_hi_addr, vec_of(exp));
    @(negedge clk);
    chk(ack == 4'b0000, "R9", ack, 0);
  endtask

  task automatic finish_fetch();
    @(negedge clk) vec_done = 1;
    @(negedge clk) vec_done = 0;
  endtask

  task automatic clear_hw();
    ext_req = 0; tmr_flag = 0; tmr_en = 0; ser_flag = 0; ser_en = 0;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(irq_pend == 0 && ack == 0, "R1", {irq_pend, ack}, 0);
    chk(vec_hi_addr == 0 && vec_lo_addr == 0, "R1", vec_hi_addr, 0);
    rst_n = 1;
    @(negedge clk);
    chk(irq_pend == 0, "R1", irq_pend, 0);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = TBL[i];
      @(negedge clk);
      mask = v[21]; ext_req = v[20]; tmr_flag = v[19:17]; tmr_en = v[16:14];
      ser_flag = v[13:9]; ser_en = v[8:4];
      if (v[22]) pulse_swi();
      @(negedge clk);
      chk(irq_pend == (v[3:0] != 0), "R3", irq_pend, v[3:0] != 0);
      at_boundary(v[3:0], "R4");
      clear_hw();
      if (v[3:0] != 0) finish_fetch();
      if (v[22] && v[3:0] != 4'b0001) begin
        at_boundary(4'b0001, "R7");
        finish_fetch();
      end
    end

    // R8: request arriving after the software strobe waits
    @(negedge clk) mask = 0;
    pulse_swi();
    @(negedge clk) ext_req = 1;
    at_boundary(4'b0001, "R8");
    finish_fetch();
    at_boundary(4'b0010, "R8");
    @(negedge clk) clear_hw();
    finish_fetch();

    // R7 with timer snapshot, then serial after strobe
    @(negedge clk) tmr_flag = 3'b001; tmr_en = 3'b001;
    pulse_swi();
    @(negedge clk) ser_flag = 5'b00010; ser_en = 5'b00010;
    at_boundary(4'b0100, "R7");
    @(negedge clk) tmr_flag = 0;
    finish_fetch();
    at_boundary(4'b0001, "R8");
    finish_fetch();
    at_boundary(4'b1000, "R8");
    @(negedge clk) clear_hw();
    finish_fetch();

    // R9: no grant without boundary
    @(negedge clk) ext_req = 1;
    repeat (4) @(negedge clk);
    chk(ack == 0 && irq_pend == 1, "R9", {irq_pend, ack}, 5'h10);

    // R10: hold until vec_done
    at_boundary(4'b0010, "R10");
    @(negedge clk) ext_req = 0; tmr_flag = 3'b100; tmr_en = 3'b100;
    @(negedge clk);
    chk(irq_pend == 0, "R10", irq_pend, 0);
    at_boundary(4'b0000, "R10");
    chk(vec_hi_addr == 16'h1FFA && vec_lo_addr == 16'h1FFB, "R10", vec_hi_addr, 16'h1FFA);
    finish_fetch();
    at_boundary(4'b0100, "R10");
    @(negedge clk) clear_hw();
    finish_fetch();

    // R2: software interrupt under mask while hardware is blocked
    @(negedge clk) mask = 1; ser_flag = 5'b11111; ser_en = 5'b11111;
    pulse_swi();
    at_boundary(4'b0001, "R2");
    finish_fetch();
    @(negedge clk);
    chk(irq_pend == 0, "R3", irq_pend, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule